// File: doc/BRIEF.md
# Per-Destination Input Queue Buffer

This block sits on the receive side of one port of a four-port packet switch. Every incoming packet has a fixed width. The block takes the destination address from the top byte of the packet and looks it up in a small table that can be rewritten at run time. The table gives one of four output ports. The packet is then appended to the queue kept for that output. The four queues are independent, so a packet waiting for a busy output never blocks packets bound elsewhere.

The oldest packet of every queue is shown on the outputs at the same time, together with its class bit and the number of packets that queue holds. A downstream arbiter can therefore grant any mix of outputs in one cycle and weigh its choice by queue depth. Data-class packets get their timestamp field overwritten on entry with the value of a free-running local counter, which lets the arbiter pick among them by age. When the queue a packet targets is full, the input holds off the packet instead of dropping it.

Top module: `voq_input_buffer`

## Requirements
- R1: After reset every queue is empty: all `head_valid` bits are 0 and all `occ` fields are 0. `in_ready` is 1. The timestamp counter is 0. Each table entry at address a holds a mod 4.
- R2: The destination of a packet is the table entry selected by the address byte `in_pkt[255:248]`. A cycle with `cfg_we` high stores `cfg_port` at entry `cfg_addr`, and the new value applies from the next cycle. A packet accepted in the same cycle as the write uses the old value.
- R3: Each accepted packet is appended to the queue of its destination, and only to that queue. `occ[j]` (field j, 3 bits) gives the number of packets held in queue j and never goes above DEPTH (4).
- R4: For every queue j at the same time, `head_valid[j]` is 1 exactly when the queue is non-empty. Slice j of `head_pkt` then shows the oldest stored packet in that queue.
- R5: Packets leave each queue in the order in which they arrived. A head that is not dequeued stays unchanged.
- R6: The bits of `deq` act independently, so any subset of queues releases its head at one clock edge. A `deq` bit for an empty queue has no effect.
- R7: While the target queue is full, `in_ready` is 0, even if that queue is dequeued in the same cycle. Nothing is stored while `in_ready` is 0. The held packet is accepted once space frees up, and no packet is lost.
- R8: A data-class packet (`in_class`=1) has bits [247:232] replaced by the counter value at the accepting edge. The counter starts at 0 after reset and advances by one every clock. A priority-class packet (`in_class`=0) is stored unchanged.
- R9: An enqueue and a dequeue on the same non-empty queue in one cycle both take effect, and its `occ` stays the same.
- R10: `head_class[j]` gives the class bit stored with the head packet of queue j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Table entry to write |
| cfg_port | input | 2 | Output port written into the entry |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Target queue can accept the packet |
| in_class | input | 1 | 1 = data class (stamped), 0 = priority class |
| in_pkt | input | 256 | Packet, address byte in the top bits |
| head_valid | output | 4 | Per-queue head present |
| head_class | output | 4 | Class bit of each head |
| head_pkt | output | 1024 | Head packet of queue j at bits [256*j +: 256] |
| occ | output | 12 | Packet count of queue j at bits [3*j +: 3] |
| deq | input | 4 | Per-queue release of the head |

## Verification
The case hardest to reach from the ports is a full queue that is dequeued while a packet for that same queue waits at the input. Here `in_ready` must stay low and the packet must get in on the following cycle, not be lost. The bench fills one queue to DEPTH and holds a packet for it on the input. It then raises that queue's `deq` bit in the same cycle and checks the backpressure, the count and the late acceptance. A table write that coincides with a packet for the rewritten address is set up in the same deliberate way. Beyond these, a sweep over all 256 addresses under a rewritten mapping, with varied dequeue masks, checks every head and count against a model kept in the bench.

// File: rtl/voq_input_buffer.sv
module voq_input_buffer #(
  parameter int NOUT   = 4,
  parameter int DEPTH  = 4,
  parameter int PKT_W  = 256,
  parameter int ADDR_W = 8,
  parameter int TS_W   = 16,
  localparam int DW    = $clog2(NOUT),
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int NENT  = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [DW-1:0]         cfg_port,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_class,
  input  logic [PKT_W-1:0]      in_pkt,
  output logic [NOUT-1:0]       head_valid,
  output logic [NOUT-1:0]       head_class,
  output logic [NOUT*PKT_W-1:0] head_pkt,
  output logic [NOUT*CW-1:0]    occ,
  input  logic [NOUT-1:0]       deq
);

  logic [DW-1:0]   xlat [NENT];
  logic [DW-1:0]   tgt;
  logic [TS_W-1:0] ts_cnt;
  logic [NOUT-1:0] full;
  logic [PKT_W-1:0] stamped;
  logic            accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) xlat[i] <= DW'(i % NOUT);
    end else if (cfg_we) begin
      xlat[cfg_addr] <= cfg_port;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ts_cnt <= '0;
    else        ts_cnt <= ts_cnt + 1'b1;
  end

  assign tgt      = xlat[in_pkt[PKT_W-1 -: ADDR_W]];
  assign in_ready = !full[tgt];
  assign accept   = in_valid && in_ready;

  always_comb begin
    stamped = in_pkt;
    if (in_class) stamped[PKT_W-ADDR_W-1 -: TS_W] = ts_cnt;
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_q
    logic [PKT_W:0]  mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            push, pop;

    assign push = accept && (tgt == DW'(g));
    assign pop  = deq[g] && (cnt != '0);

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= {in_class, stamped};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end

    assign full[g]                   = (cnt == CW'(DEPTH));
    assign head_valid[g]             = (cnt != '0);
    assign head_class[g]             = mem[rp][PKT_W];
    assign head_pkt[g*PKT_W +: PKT_W] = mem[rp][PKT_W-1:0];
    assign occ[g*CW +: CW]           = cnt;
  end

endmodule

// File: rtl/voq_input_buffer_chk.sv
module voq_input_buffer_chk #(
  parameter int NOUT   = 4,
  parameter int DEPTH  = 4,
  parameter int PKT_W  = 256,
  parameter int ADDR_W = 8,
  parameter int TS_W   = 16,
  localparam int DW    = $clog2(NOUT),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_class,
  input logic [NOUT-1:0]       head_valid,
  input logic [NOUT*PKT_W-1:0] head_pkt,
  input logic [NOUT*CW-1:0]    occ,
  input logic [NOUT-1:0]       deq,
  input logic [DW-1:0]         tgt,
  input logic [TS_W-1:0]       ts_cnt
);

  for (genvar j = 0; j < NOUT; j++) begin : g_c
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ[j*CW +: CW] <= CW'(DEPTH));

    // R4
    head_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid[j] == (occ[j*CW +: CW] != '0));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid[j] && !deq[j]) |=> $stable(head_pkt[j*PKT_W +: PKT_W]));

    // R6
    deq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid[j] && deq[j] && !(in_valid && in_ready && tgt == DW'(j)))
      |=> occ[j*CW +: CW] == $past(occ[j*CW +: CW]) - 1'b1);

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready && tgt == DW'(j) && !deq[j])
      |=> occ[j*CW +: CW] == $past(occ[j*CW +: CW]));

    // R8
    stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_class && tgt == DW'(j) && !head_valid[j])
      |=> head_pkt[j*PKT_W + PKT_W - ADDR_W - 1 -: TS_W] == $past(ts_cnt));
  end

endmodule

bind voq_input_buffer voq_input_buffer_chk #(
  .NOUT(NOUT), .DEPTH(DEPTH), .PKT_W(PKT_W), .ADDR_W(ADDR_W), .TS_W(TS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_class(in_class), .head_valid(head_valid), .head_pkt(head_pkt),
  .occ(occ), .deq(deq), .tgt(tgt), .ts_cnt(ts_cnt)
);

// File: tb/voq_input_buffer_test.sv
module voq_input_buffer_test;
  localparam int NOUT = 4, DEPTH = 4, PKT_W = 256, CW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0;
  logic [1:0] cfg_port = 0;
  logic in_valid = 0, in_class = 0;
  logic in_ready;
  logic [PKT_W-1:0] in_pkt = '0;
  logic [NOUT-1:0] head_valid, head_class, deq = 0;
  logic [NOUT*PKT_W-1:0] head_pkt;
  logic [NOUT*CW-1:0] occ;

  voq_input_buffer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_port(cfg_port), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_pkt(in_pkt), .head_valid(head_valid),
    .head_class(head_class), .head_pkt(head_pkt), .occ(occ), .deq(deq)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] bts;
  logic [31:0] seq = 1;
  logic [1:0]  map [256];
  logic [PKT_W:0] mq [4][$];

  always @(posedge clk) if (!rst_n) bts <= 0; else bts <= bts + 1;

  task automatic chk(bit ok, string r, logic [PKT_W-1:0] act, logic [PKT_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic check_all(string r);
    for (int j = 0; j < NOUT; j++) begin
      chk(occ[j*CW +: CW] == CW'(mq[j].size()), {r, " occ"}, PKT_W'(occ[j*CW +: CW]), PKT_W'(mq[j].size()));
      chk(head_valid[j] == (mq[j].size() != 0), {r, " R4 head_valid"}, PKT_W'(head_valid[j]), PKT_W'(mq[j].size() != 0));
      if (mq[j].size() != 0) begin
        chk(head_pkt[j*PKT_W +: PKT_W] == mq[j][0][PKT_W-1:0], {r, " R4 R5 head_pkt"}, head_pkt[j*PKT_W +: PKT_W], mq[j][0][PKT_W-1:0]);
        chk(head_class[j] == mq[j][0][PKT_W], {r, " R10 head_class"}, PKT_W'(head_class[j]), PKT_W'(mq[j][0][PKT_W]));
      end
    end
  endtask

  function automatic logic [PKT_W-1:0] mk(logic [7:0] a, logic [31:0] s);
    return {a, {7{s}}, s[23:0]};
  endfunction

  function automatic logic [PKT_W:0] stored(logic c, logic [PKT_W-1:0] p, logic [15:0] t);
    logic [PKT_W-1:0] q = p;
    if (c) q[247:232] = t;
    return {c, q};
  endfunction

  // drive at negedge; inputs already set for deq/cfg by caller
  task automatic send(logic [7:0] a, logic c);
    logic [PKT_W-1:0] p = mk(a, seq);
    seq++;
    @(negedge clk);
    in_valid = 1; in_class = c; in_pkt = p;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    mq[map[a]].push_back(stored(c, p, bts));
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic pop(logic [3:0] m);
    @(negedge clk);
    deq = m;
    @(posedge clk); #1;
    deq = 0;
    for (int j = 0; j < NOUT; j++) if (m[j] && mq[j].size() != 0) void'(mq[j].pop_front());
  endtask

  task automatic wr_map(logic [7:0] a, logic [1:0] p);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_port = p;
    @(posedge clk); #1;
    cfg_we = 0;
    map[a] = p;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) map[a] = 2'(a % 4);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1 reset state
    chk(head_valid == 0, "R1 head_valid", PKT_W'(head_valid), 0);
    chk(occ == 0, "R1 occ", PKT_W'(occ), 0);
    chk(in_ready == 1, "R1 in_ready", PKT_W'(in_ready), 1);
    check_all("R1");

    // R1 R2 default mapping, mixed classes, R8 stamp
    for (int a = 0; a < 8; a++) begin
      send(8'(a * 37), a[0]);
      check_all("R2 R3 R8 default map");
    end
    pop(4'hF); check_all("R6 all deq");
    pop(4'h5); check_all("R6 partial deq");
    pop(4'hF); check_all("R6 deq to empty");
    pop(4'hF); check_all("R6 deq on empty ignored");
    chk(occ == 0, "R6 empty after idle deq", PKT_W'(occ), 0);

    // R2 table write coinciding with a packet for that entry
    begin
      logic [PKT_W-1:0] p = mk(8'd9, seq);
      seq++;
      @(negedge clk);
      cfg_we = 1; cfg_addr = 8'd9; cfg_port = 2'd3;
      in_valid = 1; in_class = 0; in_pkt = p;
      @(posedge clk); #1;
      cfg_we = 0; in_valid = 0;
      mq[1].push_back(stored(0, p, 0));
      map[9] = 2'd3;
      check_all("R2 same-cycle write uses old entry");
      send(8'd9, 0);
      check_all("R2 new entry applies");
      pop(4'hF); pop(4'hF);
    end

    // R7 fill queue 2, hold a packet while dequeuing the full queue
    for (int k = 0; k < DEPTH; k++) send(8'd2, k[0]);
    check_all("R3 full queue");
    chk(occ[2*CW +: CW] == 3'd4, "R3 occ at DEPTH", PKT_W'(occ[2*CW +: CW]), 4);
    begin
      logic [PKT_W-1:0] p = mk(8'd6, seq);
      seq++;
      @(negedge clk);
      in_valid = 1; in_class = 1; in_pkt = p;
      #1 chk(in_ready == 0, "R7 ready low when full", PKT_W'(in_ready), 0);
      @(posedge clk); #1;
      check_all("R7 held packet not stored");
      @(negedge clk);
      deq = 4'b0100;
      #1 chk(in_ready == 0, "R7 ready low despite deq", PKT_W'(in_ready), 0);
      @(posedge clk); #1;
      deq = 0;
      void'(mq[2].pop_front());
      check_all("R7 deq while held");
      @(negedge clk); #1;
      chk(in_ready == 1, "R7 ready after space", PKT_W'(in_ready), 1);
      mq[2].push_back(stored(1, p, bts));
      @(posedge clk); #1;
      in_valid = 0;
      check_all("R7 late accept no loss");
      for (int k = 0; k < DEPTH; k++) begin pop(4'b0100); check_all("R5 drain order"); end
    end

    // R9 simultaneous enqueue and dequeue on one queue
    send(8'd1, 0);
    begin
      logic [PKT_W-1:0] p = mk(8'd1, seq);
      seq++;
      @(negedge clk);
      in_valid = 1; in_class = 1; in_pkt = p; deq = 4'b0010;
      #1;
      mq[1].push_back(stored(1, p, bts));
      @(posedge clk); #1;
      in_valid = 0; deq = 0;
      void'(mq[1].pop_front());
      chk(occ[1*CW +: CW] == 3'd1, "R9 occ unchanged", PKT_W'(occ[1*CW +: CW]), 1);
      check_all("R9 enq+deq");
      pop(4'hF);
    end

    // rewrite the whole table, sweep every address
    for (int a = 0; a < 256; a++) wr_map(8'(a), 2'((a * 3 + 1) % 4));
    for (int a = 0; a < 256; a++) begin
      if (mq[map[a]].size() == DEPTH) pop(4'hF);
      send(8'(a), a[1]);
      check_all("R2 R3 R8 sweep");
      if (a % 5 == 4) begin pop(4'(a / 5)); check_all("R5 R6 sweep deq"); end
    end
    while (mq[0].size() + mq[1].size() + mq[2].size() + mq[3].size() != 0) begin
      pop(4'hF); check_all("R5 final drain");
    end

    finish_run();
  end
endmodule